// File: doc/BRIEF.md
# Dual-Channel Chained-Grant Interrupt Controller

This block is the interrupt end of a peripheral interface on a shared bus. Bus priority on that bus is settled by a grant that is passed from device to device along a chain. The block holds two request channels in one chain position. Channel 0 (A) outranks channel 1 (B). Each channel has an enable flip-flop. The flip-flop loads the channel's enable-data bit, normally a control/status register bit, at the moment the channel's local request line rises. A channel raises the shared, active-low bus interrupt request only while its request line is high, its enable is set, and its current request has not yet been served.

When the incoming grant arrives and a channel is pending, the block keeps the grant and does not pass it on. It then strobes a vector-enable output toward the data transceivers while the processor's data-in strobe is high. A select output says which channel is being acknowledged, so the vector generator can offset the vector by 4 for channel B. When the data-in strobe falls, the acknowledged channel counts as served. If no channel is pending when the grant arrives, the grant is forwarded downstream one clock later. All logic is synchronous to one clock, and `init` acts as a synchronous clear.

Top module: `irq_chain_ctrl`

## Requirements
- R1: While `init` is high at a clock edge, both enables and all served flags clear. After that edge `irq_n` is 1 and `gnt_out` and `vec_en` are 0.
- R2: A channel's enable flip-flop loads its `en_data` bit only on the clock edge where that channel's `req` is first seen high. Changes to `en_data` while `req` stays high have no effect. An enable loaded as 0 keeps the channel from requesting.
- R3: `irq_n` is 0 exactly when at least one channel has `req` high, its enable set, and is not served. Dropping `req` releases `irq_n` in the same cycle, with no clock edge needed.
- R4: If `gnt_in` is high at an edge where no channel is pending, `gnt_out` goes high after that edge. It then falls after the first edge that sees `gnt_in` low.
- R5: If a channel is pending when `gnt_in` is first seen high, the block consumes the grant, and `gnt_out` stays 0 until `gnt_in` drops.
- R6: While the block holds a grant, `vec_en` follows `din` one clock later. It is 1 after an edge that sees `din` high and 0 after an edge that sees `din` low.
- R7: `ack_sel` names the acknowledged channel: 0 for channel A and 1 for channel B, which adds 4 to the vector. When both channels are pending at grant time, A is chosen.
- R8: The edge that sees `din` fall during an acknowledge marks the owning channel as served, which withdraws its request. It stays served, and a later grant passes through it, until its `req` goes low and rises again.
- R9: A `din` strobe while the block holds no grant (idle or forwarding) leaves `vec_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init | input | 1 | Synchronous clear, active high |
| din | input | 1 | Processor data-in strobe, active high |
| gnt_in | input | 1 | Incoming chained grant, active high |
| req | input | NUM_CH (2) | Local request per channel, bit 0 = A |
| en_data | input | NUM_CH (2) | Enable data per channel, loaded when its req rises |
| irq_n | output | 1 | Shared bus interrupt request, active low |
| gnt_out | output | 1 | Grant forwarded downstream |
| vec_en | output | 1 | Vector drive enable toward transceivers |
| ack_sel | output | SEL_W (1) | Acknowledged channel, 1 = channel B |

## Verification
The assertions check several rules on every cycle: `gnt_out` and `vec_en` are never high together, `gnt_out` is only high after a sampled grant, `vec_en` is only high after a sampled `din` and clears after `din` falls, an active `irq_n` always has some `req` behind it, and `init` clears the outputs. Other behaviour depends on a particular order of events, and only the bench scenarios can show it. This covers loading the enable only at the request edge, choosing A over B and then serving B on a later grant, a served channel letting a grant through, and clearing the state in the middle of an acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // grant handling state of the shared acknowledge logic
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_ACK  = 2'd2
    } ack_st_e;

    // per-channel registered state
    typedef struct packed {
        logic req_seen;   // request level seen at the previous edge
        logic enable;     // interrupt enable flip-flop
        logic served;     // current request already acknowledged
    } chan_reg_t;

endpackage

// File: rtl/irq_chain_chan.sv
module irq_chain_chan
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic init,
    input  logic req,
    input  logic en_data,
    input  logic served_pulse,
    output logic pend
);

    chan_reg_t chan_d, chan_q;
    logic      req_rise;

    always_comb begin
        req_rise        = req & ~chan_q.req_seen;
        chan_d          = chan_q;
        chan_d.req_seen = req;
        if (req_rise) begin
            chan_d.enable = en_data;
        end
        if (!req || req_rise) begin
            chan_d.served = 1'b0;
        end else if (served_pulse) begin
            chan_d.served = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (init) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign pend = req & chan_q.enable & ~chan_q.served;

endmodule

// File: rtl/irq_chain_ack.sv
module irq_chain_ack
    import irq_chain_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              init,
    input  logic              gnt_in,
    input  logic              din,
    input  logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] served,
    output logic              gnt_out,
    output logic              vec_en,
    output logic [SEL_W-1:0]  sel
);

    typedef struct packed {
        ack_st_e          st;
        logic [SEL_W-1:0] owner;
        logic             din_seen;
        logic             gnt_fwd;
        logic             vec_drv;
    } ack_reg_t;

    ack_reg_t         ack_d, ack_q;
    logic [SEL_W-1:0] winner;
    logic             any_pend;

    // lowest index wins: scan downward so the last hit is the highest priority
    always_comb begin
        winner = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                winner = SEL_W'(i);
            end
        end
        any_pend = |pend;
    end

    always_comb begin
        ack_d          = ack_q;
        ack_d.din_seen = din;
        ack_d.gnt_fwd  = 1'b0;
        ack_d.vec_drv  = 1'b0;
        served         = '0;
        case (ack_q.st)
            ST_IDLE: begin
                if (gnt_in) begin
                    if (any_pend) begin
                        ack_d.st    = ST_ACK;
                        ack_d.owner = winner;
                    end else begin
                        ack_d.st      = ST_PASS;
                        ack_d.gnt_fwd = 1'b1;
                    end
                end
            end
            ST_PASS: begin
                if (gnt_in) begin
                    ack_d.gnt_fwd = 1'b1;
                end else begin
                    ack_d.st = ST_IDLE;
                end
            end
            ST_ACK: begin
                ack_d.vec_drv = din;
                if (ack_q.din_seen && !din) begin
                    served[ack_q.owner] = 1'b1;
                end
                if (!gnt_in) begin
                    ack_d.st = ST_IDLE;
                end
            end
            default: ack_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (init) begin
            ack_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ack_q <= ack_d;
        end
    end

    assign gnt_out = ack_q.gnt_fwd;
    assign vec_en  = ack_q.vec_drv;
    assign sel     = ack_q.owner;

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
    parameter  int NUM_CH = 2,
    localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              init,
    input  logic              din,
    input  logic              gnt_in,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] en_data,
    output logic              irq_n,
    output logic              gnt_out,
    output logic              vec_en,
    output logic [SEL_W-1:0]  ack_sel
);

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] served;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        irq_chain_chan u_chan (
            .clk          (clk),
            .init         (init),
            .req          (req[g]),
            .en_data      (en_data[g]),
            .served_pulse (served[g]),
            .pend         (pend[g])
        );
    end

    irq_chain_ack #(.NUM_CH(NUM_CH)) u_ack (
        .clk     (clk),
        .init    (init),
        .gnt_in  (gnt_in),
        .din     (din),
        .pend    (pend),
        .served  (served),
        .gnt_out (gnt_out),
        .vec_en  (vec_en),
        .sel     (ack_sel)
    );

    assign irq_n = ~(|pend);

endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk #(
    parameter  int NUM_CH = 2,
    localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              init,
    input logic              din,
    input logic              gnt_in,
    input logic [NUM_CH-1:0] req,
    input logic              irq_n,
    input logic              gnt_out,
    input logic              vec_en,
    input logic [SEL_W-1:0]  ack_sel
);

    p_init_clear_r1: assert property (@(posedge clk)
        init |=> (irq_n && !gnt_out && !vec_en));

    p_irq_has_req_r3: assert property (@(posedge clk) disable iff (init)
        !irq_n |-> (|req));

    p_fwd_after_grant_r4: assert property (@(posedge clk) disable iff (init)
        gnt_out |-> $past(gnt_in));

    p_no_fwd_while_vec_r5: assert property (@(posedge clk) disable iff (init)
        !(gnt_out && vec_en));

    p_vec_after_din_r6: assert property (@(posedge clk) disable iff (init)
        vec_en |-> $past(din));

    p_vec_drops_r6: assert property (@(posedge clk) disable iff (init)
        $fell(din) |=> !vec_en);

    p_sel_stable_r7: assert property (@(posedge clk) disable iff (init)
        (vec_en && $past(vec_en)) |-> $stable(ack_sel));

endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .init    (init),
    .din     (din),
    .gnt_in  (gnt_in),
    .req     (req),
    .irq_n   (irq_n),
    .gnt_out (gnt_out),
    .vec_en  (vec_en),
    .ack_sel (ack_sel)
);

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;

    logic       clk = 1'b0;
    logic       init;
    logic       din;
    logic       gnt_in;
    logic [1:0] req;
    logic [1:0] en_data;
    logic       irq_n;
    logic       gnt_out;
    logic       vec_en;
    logic [0:0] ack_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_chain_ctrl u_irq_chain_ctrl (
        .clk     (clk),
        .init    (init),
        .din     (din),
        .gnt_in  (gnt_in),
        .req     (req),
        .en_data (en_data),
        .irq_n   (irq_n),
        .gnt_out (gnt_out),
        .vec_en  (vec_en),
        .ack_sel (ack_sel)
    );

    // row: req[1:0] en[1:0] gnt din | exp irq_n gnt_out vec_en sel
    localparam logic [9:0] TBL [23] = '{
        10'b01_01_0_0_0_0_0_0,  // 0  R3 A enabled at req edge
        10'b01_00_0_0_0_0_0_0,  // 1  R2 en change while req held ignored
        10'b01_00_1_0_0_0_0_0,  // 2  R5 grant consumed
        10'b01_00_1_1_0_0_1_0,  // 3  R6 vector strobe, A
        10'b01_00_1_0_1_0_0_0,  // 4  R8 served on din fall
        10'b01_00_0_0_1_0_0_0,  // 5
        10'b01_00_1_0_1_1_0_0,  // 6  R8 served channel passes grant (R4)
        10'b01_00_0_0_1_0_0_0,  // 7  R4 forward drops
        10'b00_00_0_0_1_0_0_0,  // 8
        10'b11_11_0_0_0_0_0_0,  // 9  R3 both enabled
        10'b11_11_1_0_0_0_0_0,  // 10 R5
        10'b11_11_1_1_0_0_1_0,  // 11 R7 A wins
        10'b11_11_1_0_0_0_0_0,  // 12 R8 B still pending
        10'b11_11_0_0_0_0_0_0,  // 13
        10'b11_11_1_0_0_0_0_1,  // 14 R5 second grant
        10'b11_11_1_1_0_0_1_1,  // 15 R7 B acknowledged
        10'b11_11_1_0_1_0_0_1,  // 16 R8 all served
        10'b11_11_0_0_1_0_0_1,  // 17
        10'b00_00_0_0_1_0_0_0,  // 18
        10'b10_00_0_0_1_0_0_0,  // 19 R2 B loaded disabled
        10'b10_00_1_0_1_1_0_0,  // 20 R4 pass through
        10'b10_00_1_1_1_1_0_0,  // 21 R9 din while forwarding
        10'b00_00_0_0_1_0_0_0   // 22
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [3:0] act,
                         input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {irq_n, gnt_out, vec_en, ack_sel[0]};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        init = 1'b1; din = 1'b0; gnt_in = 1'b0; req = '0; en_data = '0;
        step();
        step();
        init = 1'b0;
        step();
        // R1 state after clear
        check(irq_n && !gnt_out && !vec_en, "R1 reset state", outs(), 4'b1000);

        for (int r = 0; r < 23; r++) begin
            logic [9:0] v;
            logic [3:0] e;
            bit         ok;
            v = TBL[r];
            req = v[9:8]; en_data = v[7:6]; gnt_in = v[5]; din = v[4];
            e = v[3:0];
            step();
            ok = (irq_n == e[3]) && (gnt_out == e[2]) && (vec_en == e[1]);
            if (e[1]) ok = ok && (ack_sel[0] == e[0]);
            check(ok, $sformatf("table row %0d (R2..R9 per row)", r), outs(), e);
        end

        // R9: din while idle
        din = 1'b1;
        step();
        check(!vec_en, "R9 din while idle", outs(), 4'b1000);
        din = 1'b0;
        step();

        // R3: withdrawal releases irq_n without a clock edge
        req = 2'b01; en_data = 2'b01;
        step();
        check(!irq_n, "R3 request raised", outs(), 4'b0000);
        req = 2'b00;
        #1;
        check(irq_n, "R3 withdraw same cycle", outs(), 4'b1000);
        step();

        // R1: clear during an acknowledge
        req = 2'b01; en_data = 2'b01;
        step();
        gnt_in = 1'b1;
        step();
        din = 1'b1;
        step();
        check(vec_en && !gnt_out, "R6 strobe before clear", outs(), 4'b0010);
        init = 1'b1;
        step();
        check(irq_n && !gnt_out && !vec_en, "R1 clear mid-acknowledge", outs(), 4'b1000);
        init = 1'b0; din = 1'b0; gnt_in = 1'b0; en_data = 2'b00;
        step();
        check(irq_n, "R2 reload after clear with enable 0", outs(), 4'b1000);
        req = 2'b00;
        step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule